// File: doc/BRIEF.md
# Configurable-Array Coprocessor Controller

This controller connects a scalar processor to a configurable array that acts as a coprocessor. The processor sends one instruction at a time. Each instruction carries an opcode, a short configuration name, a data word and a cycle count. A configure instruction names the array function to use. Two move-to instructions load the array's two operand registers. A run instruction starts a multi-cycle operation. A move-from instruction returns the array's result to the processor.

The controller keeps a four-entry residency table of loaded configurations, ordered by recency of use. A name that is already resident becomes active at once. A name that is not resident asks an external loader for it and waits for that loader to finish. During a run, a down-counter holds the processor stalled. The array stub keeps an accumulator that changes on every busy cycle, so each operation carries state from one cycle to the next.

An instruction is taken on a rising edge when `ins_valid` is high and `stall` is low. While `stall` is high the processor must hold the instruction steady.

Top module: `rcop_ctrl`

## Requirements
- R1: After synchronous reset, `stall`, `load_req`, `res_valid` and `act_valid` are 0, the operand registers are 0, the accumulator is 0 and every table entry is empty.
- R2: A configure instruction (op 1) whose name is resident makes that entry active on the next cycle. `act_valid` is 1 and `act_id` shows the name, and `stall` is not raised.
- R3: A configure instruction whose name is not resident raises `load_req` on the next cycle, with `load_id` set to the name. It also clears `act_valid`. `load_req` and `stall` stay high, with `load_id` stable, until `load_done` is sampled high. On the edge that samples it, the name is installed and becomes active.
- R4: A missed name goes into the lowest-numbered empty slot. When no slot is empty, it goes into the slot used least recently, shown on `load_slot`. Both a configure hit and a completed load count as a use.
- R5: Op 2 writes `ins_data` into operand A, and op 3 writes it into operand B.
- R6: Op 4 with count N (0 to 255) holds `stall` high for exactly N cycles, starting the cycle after it is taken. N = 0 raises no stall.
- R7: A run seeds the accumulator with A. On each busy cycle it applies the function chosen by the active name's two low bits: 0 gives acc+B, 1 gives rotate-left-by-one(acc) XOR B, 2 gives acc−B, and 3 gives (acc XOR B)+1.
- R8: Op 5 returns the accumulator on the next cycle, with a one-cycle `res_valid` pulse. If it is held during a run, it is taken when the run ends and returns the final value.
- R9: Op 0 and ops 6 and 7 change no state. While `stall` is high, no instruction is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction present |
| ins_op | input | 3 | Opcode |
| ins_id | input | 4 | Configuration name |
| ins_data | input | 32 | Operand data |
| ins_cnt | input | 8 | Run cycle count |
| stall | output | 1 | Processor must hold |
| load_req | output | 1 | Configuration load wanted |
| load_id | output | 4 | Name to load |
| load_slot | output | 2 | Slot being filled |
| load_done | input | 1 | Loader finished |
| act_valid | output | 1 | A configuration is active |
| act_id | output | 4 | Active name |
| res_valid | output | 1 | Result word present |
| res_data | output | 32 | Result word |

## Verification
Every result is registered. A configure hit shows on `act_id` one cycle after it is taken. A miss shows on `load_req` one cycle later, and the new name becomes active one cycle after `load_done` is sampled. A run asserts `stall` from the next cycle for N cycles, and a move-from shows its word one cycle after it is taken. The bench keeps a behavioural model that updates on the same rising edge as the design. It compares every output at the following falling edge, so each check falls exactly in the cycle where the result is due.

// File: rtl/rcop_pkg.sv
package rcop_pkg;
    localparam int DATA_W = 32;
    localparam int ID_W   = 4;
    localparam int CNT_W  = 8;
    localparam int SLOTS  = 4;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_CFG = 3'd1,
        OP_MTA = 3'd2,
        OP_MTB = 3'd3,
        OP_RUN = 3'd4,
        OP_MFR = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        FN_ADD  = 2'd0,
        FN_ROTX = 2'd1,
        FN_SUB  = 2'd2,
        FN_XINC = 2'd3
    } fn_e;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } operands_t;
endpackage

// File: rtl/rcop_ctx_table.sv
module rcop_ctx_table #(
    parameter int SLOTS = 4,
    parameter int ID_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_req,
    input  logic [ID_W-1:0]          cfg_id,
    input  logic                     load_done,
    output logic                     load_req,
    output logic [ID_W-1:0]          load_id,
    output logic [$clog2(SLOTS)-1:0] load_slot,
    output logic                     act_valid,
    output logic [ID_W-1:0]          act_id
);
    localparam int SW = $clog2(SLOTS);

    logic [SLOTS-1:0] vld;
    logic [ID_W-1:0]  ids [SLOTS];
    logic [SW-1:0]    age [SLOTS];
    logic [SLOTS-1:0] hit_vec;
    logic [SLOTS-1:0] age_mask;
    logic             hit;
    logic [SW-1:0]    hit_slot, free_slot, lru_slot, victim;
    logic             have_free;
    logic             pend;
    logic [ID_W-1:0]  pend_id;
    logic [SW-1:0]    pend_slot;
    logic             act_v;
    logic [SW-1:0]    act_s;
    logic             touch_en;
    logic [SW-1:0]    touch_slot;

    for (genvar i = 0; i < SLOTS; i++) begin : g_hit
        assign hit_vec[i] = vld[i] && (ids[i] == cfg_id);
    end

    always_comb begin
        hit_slot  = '0;
        free_slot = '0;
        lru_slot  = '0;
        have_free = 1'b0;
        age_mask  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (hit_vec[i]) hit_slot = SW'(i);
            if (age[i] == SW'(SLOTS - 1)) lru_slot = SW'(i);
            age_mask = age_mask | (SLOTS'(1) << age[i]);
        end
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_slot = SW'(i);
                have_free = 1'b1;
            end
        end
        hit    = |hit_vec;
        victim = have_free ? free_slot : lru_slot;
    end

    assign touch_en   = (cfg_req && hit) || (pend && load_done);
    assign touch_slot = pend ? pend_slot : hit_slot;

    for (genvar i = 0; i < SLOTS; i++) begin : g_age
        always_ff @(posedge clk) begin
            if (rst) begin
                age[i] <= SW'(i);
            end else if (touch_en) begin
                if (touch_slot == SW'(i)) begin
                    age[i] <= '0;
                end else if (age[i] < age[touch_slot]) begin
                    age[i] <= age[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld       <= '0;
            pend      <= 1'b0;
            pend_id   <= '0;
            pend_slot <= '0;
            act_v     <= 1'b0;
            act_s     <= '0;
            for (int i = 0; i < SLOTS; i++) ids[i] <= '0;
        end else if (pend && load_done) begin
            vld[pend_slot] <= 1'b1;
            ids[pend_slot] <= pend_id;
            pend           <= 1'b0;
            act_v          <= 1'b1;
            act_s          <= pend_slot;
        end else if (cfg_req) begin
            if (hit) begin
                act_v <= 1'b1;
                act_s <= hit_slot;
            end else begin
                pend        <= 1'b1;
                pend_id     <= cfg_id;
                pend_slot   <= victim;
                vld[victim] <= 1'b0;
                act_v       <= 1'b0;
            end
        end
    end

    assign load_req  = pend;
    assign load_id   = pend_id;
    assign load_slot = pend_slot;
    assign act_valid = act_v;
    assign act_id    = ids[act_s];

    AST_LOAD_HELD: assert property (@(posedge clk) disable iff (rst)
        (pend && !load_done) |=> (pend && $stable(pend_id) && $stable(pend_slot))); // R3
    AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (rst)
        $countones(age_mask) == SLOTS); // R4
    AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R4
    AST_ACTIVE_RESIDENT: assert property (@(posedge clk) disable iff (rst)
        act_v |-> vld[act_s]); // R2
endmodule

// File: rtl/rcop_array_stub.sv
module rcop_array_stub
    import rcop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  run_cnt,
    input  logic [DATA_W-1:0] seed,
    input  logic [DATA_W-1:0] opb,
    input  logic [1:0]        fsel,
    output logic              busy,
    output logic [DATA_W-1:0] result
);
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] nxt;

    always_comb begin
        case (fn_e'(fsel))
            FN_ADD:  nxt = acc + opb;
            FN_ROTX: nxt = {acc[DATA_W-2:0], acc[DATA_W-1]} ^ opb;
            FN_SUB:  nxt = acc - opb;
            default: nxt = (acc ^ opb) + 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            acc <= '0;
        end else if (start) begin
            cnt <= run_cnt;
            acc <= seed;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            acc <= nxt;
        end
    end

    assign busy   = (cnt != '0);
    assign result = acc;

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && !start) |=> (cnt == CNT_W'($past(cnt) - 1'b1))); // R6
    AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !start) |=> $stable(acc)); // R7
endmodule

// File: rtl/rcop_ctrl.sv
module rcop_ctrl
    import rcop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [2:0]        ins_op,
    input  logic [ID_W-1:0]   ins_id,
    input  logic [DATA_W-1:0] ins_data,
    input  logic [CNT_W-1:0]  ins_cnt,
    output logic              stall,
    output logic              load_req,
    output logic [ID_W-1:0]   load_id,
    output logic [$clog2(SLOTS)-1:0] load_slot,
    input  logic              load_done,
    output logic              act_valid,
    output logic [ID_W-1:0]   act_id,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);
    op_e               op;
    logic              take;
    logic              busy;
    logic [DATA_W-1:0] result;
    operands_t         opr;
    logic              rv;
    logic [DATA_W-1:0] rd;

    assign op    = op_e'(ins_op);
    assign stall = load_req || busy;
    assign take  = ins_valid && !stall;

    rcop_ctx_table #(.SLOTS(SLOTS), .ID_W(ID_W)) i_table (
        .clk       (clk),
        .rst       (rst),
        .cfg_req   (take && op == OP_CFG),
        .cfg_id    (ins_id),
        .load_done (load_done),
        .load_req  (load_req),
        .load_id   (load_id),
        .load_slot (load_slot),
        .act_valid (act_valid),
        .act_id    (act_id)
    );

    rcop_array_stub #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_array (
        .clk     (clk),
        .rst     (rst),
        .start   (take && op == OP_RUN),
        .run_cnt (ins_cnt),
        .seed    (opr.a),
        .opb     (opr.b),
        .fsel    (act_id[1:0]),
        .busy    (busy),
        .result  (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opr <= '0;
            rv  <= 1'b0;
            rd  <= '0;
        end else begin
            rv <= take && op == OP_MFR;
            if (take && op == OP_MFR) rd <= result;
            if (take && op == OP_MTA) opr.a <= ins_data;
            if (take && op == OP_MTB) opr.b <= ins_data;
        end
    end

    assign res_valid = rv;
    assign res_data  = rd;

    AST_RESULT_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(ins_valid && !stall && ins_op == OP_MFR)); // R8
    AST_RUN_STALLS: assert property (@(posedge clk) disable iff (rst)
        (take && op == OP_RUN && ins_cnt != '0) |=> stall); // R6
    AST_MISS_REQUESTS: assert property (@(posedge clk) disable iff (rst)
        $rose(load_req) |-> (!act_valid && stall)); // R3
endmodule

// File: tb/test_rcop_ctrl.sv
module test_rcop_ctrl;
    import rcop_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic [2:0]  ins_op = 3'd0;
    logic [3:0]  ins_id = 4'd0;
    logic [31:0] ins_data = 32'd0;
    logic [7:0]  ins_cnt = 8'd0;
    logic        stall, load_req, act_valid, res_valid;
    logic [3:0]  load_id, act_id;
    logic [1:0]  load_slot;
    logic        load_done = 1'b0;
    logic [31:0] res_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ld_wait = 0;
    string cur_req = "R7";

    always #5 clk = ~clk;

    rcop_ctrl i_rcop_ctrl (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_op(ins_op),
        .ins_id(ins_id), .ins_data(ins_data), .ins_cnt(ins_cnt),
        .stall(stall), .load_req(load_req), .load_id(load_id),
        .load_slot(load_slot), .load_done(load_done), .act_valid(act_valid),
        .act_id(act_id), .res_valid(res_valid), .res_data(res_data)
    );

    // behavioural reference model
    int          m_ids [4];
    bit          m_vld [4];
    int          lru [$];
    bit          m_pend;
    int          m_pid, m_pslot;
    bit          m_av;
    int          m_as;
    logic [31:0] m_a, m_b, m_acc, m_rd;
    int          m_cnt;
    bit          m_rv;

    function automatic logic [31:0] ref_step(int name, logic [31:0] x, logic [31:0] y);
        case (name % 4)
            0: return x + y;
            1: return {x[30:0], x[31]} ^ y;
            2: return x - y;
            default: return (x ^ y) + 32'd1;
        endcase
    endfunction

    task automatic touch(int s);
        foreach (lru[k]) if (lru[k] == s) begin lru.delete(k); break; end
        lru.push_front(s);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_ids[k]) begin m_ids[k] = 0; m_vld[k] = 0; end
            lru = {0, 1, 2, 3};
            m_pend = 0; m_pid = 0; m_pslot = 0; m_av = 0; m_as = 0;
            m_a = 0; m_b = 0; m_acc = 0; m_rd = 0; m_cnt = 0; m_rv = 0;
        end else begin
            bit tk;
            tk = ins_valid && !(m_pend || m_cnt != 0);
            m_rv = tk && ins_op == 3'd5;
            if (m_rv) m_rd = m_acc;
            if (tk && ins_op == 3'd4) begin
                m_cnt = ins_cnt; m_acc = m_a;
            end else if (m_cnt != 0) begin
                m_acc = ref_step(m_ids[m_as], m_acc, m_b);
                m_cnt--;
            end
            if (tk && ins_op == 3'd2) m_a = ins_data;
            if (tk && ins_op == 3'd3) m_b = ins_data;
            if (m_pend && load_done) begin
                m_vld[m_pslot] = 1; m_ids[m_pslot] = m_pid;
                m_pend = 0; m_av = 1; m_as = m_pslot; touch(m_pslot);
            end else if (tk && ins_op == 3'd1) begin
                int h;
                h = -1;
                foreach (m_ids[k]) if (m_vld[k] && m_ids[k] == int'(ins_id)) h = k;
                if (h >= 0) begin
                    m_av = 1; m_as = h; touch(h);
                end else begin
                    int v;
                    v = -1;
                    for (int k = 3; k >= 0; k--) if (!m_vld[k]) v = k;
                    if (v < 0) v = lru[$];
                    m_pend = 1; m_pid = ins_id; m_pslot = v;
                    m_vld[v] = 0; m_av = 0;
                end
            end
        end
    end

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 1) begin
            check("R6", "stall", stall, m_pend || m_cnt != 0);
            check("R3", "load_req", load_req, m_pend);
            if (m_pend) begin
                check("R3", "load_id", load_id, m_pid);
                check("R4", "load_slot", load_slot, m_pslot);
            end
            check("R2", "act_valid", act_valid, m_av);
            if (m_av) check("R2", "act_id", act_id, m_ids[m_as]);
            check("R8", "res_valid", res_valid, m_rv);
            if (m_rv) check(cur_req, "res_data", res_data, m_rd);
        end
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // configuration loader: answers each request after three cycles
    always @(negedge clk) begin
        if (rst) begin
            ld_wait = 0; load_done = 0;
        end else if (load_req && !load_done) begin
            ld_wait++;
            if (ld_wait == 3) begin load_done = 1; ld_wait = 0; end
        end else begin
            load_done = 0;
        end
    end

    task automatic issue(int op, int id, logic [31:0] d, int n);
        ins_valid = 1; ins_op = 3'(op); ins_id = 4'(id); ins_data = d; ins_cnt = 8'(n);
        while (stall) @(negedge clk);
        @(negedge clk);
        ins_valid = 0; ins_op = 3'd0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst = 0;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1", "reset stall", stall, 0);
        check("R1", "reset load_req", load_req, 0);
        check("R1", "reset act_valid", act_valid, 0);
        check("R1", "reset res_valid", res_valid, 0);
        cur_req = "R1";
        issue(5, 0, 0, 0); idle(1);               // accumulator reads 0
        cur_req = "R7";
        issue(1, 5, 0, 0); idle(6);               // R3 miss into slot 0 (R4)
        issue(2, 0, 32'h8000_000A, 0);            // R5 operand A
        issue(3, 0, 32'h0000_0003, 0);            // R5 operand B
        issue(4, 0, 0, 4);                         // R6 run four cycles, rotate-xor
        issue(5, 0, 0, 0); idle(1);               // R8 move-from held during run
        issue(1, 6, 0, 0); issue(1, 7, 0, 0); issue(1, 8, 0, 0); idle(2);
        issue(1, 5, 0, 0); idle(1);               // R2 hit, refreshes slot 0
        issue(1, 9, 0, 0); idle(6);               // R4 victim is slot 1
        issue(1, 6, 0, 0); idle(6);               // R4 victim is slot 2
        issue(1, 8, 0, 0); idle(1);               // R2 hit, id 8 add
        issue(4, 0, 0, 10); issue(5, 0, 0, 0); idle(1);
        issue(1, 6, 0, 0);                         // sub
        issue(2, 0, 32'd100, 0); issue(3, 0, 32'd7, 0);
        cur_req = "R5";
        issue(4, 0, 0, 0); issue(5, 0, 0, 0); idle(1);   // R6 zero-length run returns A
        cur_req = "R7";
        issue(4, 0, 0, 255); issue(5, 0, 0, 0); idle(1);
        issue(1, 7, 0, 0); idle(6);               // xor-increment
        issue(4, 0, 0, 3); issue(5, 0, 0, 0); issue(5, 0, 0, 0); idle(2);
        cur_req = "R9";
        issue(0, 0, 32'hFFFF_FFFF, 9); issue(6, 3, 32'h1234, 9); issue(7, 2, 32'h55, 9);
        issue(5, 0, 0, 0); idle(1);               // ignored ops left result intact
        issue(4, 0, 0, 2);
        issue(2, 0, 32'hDEAD_BEEF, 0);            // R9 held until the run ends
        issue(4, 0, 0, 1); issue(5, 0, 0, 0); idle(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule